// File: doc/BRIEF.md
# Soft Input Formatter and Channel Error Estimator

This block sits in front of an iterative soft-decision decoder. Each cycle it takes one word of eight 6-bit received soft values. Lane j occupies bits [6j+5:6j]. The block converts every lane into the decoder's internal sign/magnitude code. In that code the top bit of a lane is the sign and the lower five bits are a magnitude from 0 to 31. This gives 63 levels with a dead zone around zero.

The source data can arrive in three forms:
- Native sign/magnitude.
- Two's complement.
- A coarser quantisation of 1 to 5 bits, left-aligned in the lane.

For the coarse form, the block appends a half-step bit below the sample so that the value sits in the middle of its quantisation interval.

For each lane the block also reports whether the formatted magnitude is non-zero. It compares a byte of decoded hard decisions against the formatted signs to estimate channel errors. This estimate can be masked so that erased (zero-magnitude) lanes never count as errors. A population count of the estimate is provided for block statistics.

The block is a fixed two-stage pipeline, with a valid bit travelling alongside the data. The decoded byte and the mask enable are sampled in the same cycle as the soft word.

Top module: `rx_soft_formatter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock edges. A synchronous reset (`rst` high at a rising edge) drives `out_valid`, `out_word`, `mag_flags`, `err_flags` and `err_count` to zero at that edge.
- R2: With `fmt_mode` 0 (or the spare value 3), each 6-bit lane is passed unchanged. Bit 5 of a lane is the sign (1 = negative) and bits 4:0 are the magnitude.
- R3: With `fmt_mode` 1, each lane is read as a 6-bit two's complement value v. The result is sign = bit 5 of v and magnitude = |v|, except that v = -32 (binary 100000) becomes 111111. The value 100000 (negative zero) is therefore never produced in this mode.
- R4: With `fmt_mode` 2 and `prec_bits` = q in 1..5, each lane keeps its upper q bits, forces bit 5-q to 1 and clears the bits below it. When q is 0, 6 or 7, the lane passes unchanged.
- R5: `mag_flags[j]` is 0 exactly when bits 4:0 of formatted lane j are all zero (codes 0 and 32), and 1 otherwise.
- R6: With `mask_en` low, `err_flags[j]` is `hard_bits[j]` XOR bit 5 of formatted lane j.
- R7: With `mask_en` high, `err_flags[j]` is the R6 value ANDed with `mag_flags[j]`. A lane with zero magnitude never flags an error.
- R8: `err_count` equals the number of ones in `err_flags` of the same output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 48 | Eight packed 6-bit soft values, lane j at [6j+5:6j] |
| fmt_mode | input | 2 | 0 sign/magnitude, 1 two's complement, 2 reduced precision, 3 as 0 |
| prec_bits | input | 3 | Sample width q for reduced-precision mode |
| hard_bits | input | 8 | Decoded hard decisions, bit j for lane j |
| mask_en | input | 1 | Suppress error flags on zero-magnitude lanes |
| out_valid | output | 1 | Output qualifier, two cycles after `in_valid` |
| out_word | output | 48 | Formatted sign/magnitude lanes |
| mag_flags | output | 8 | Non-zero magnitude indicator per lane |
| err_flags | output | 8 | Estimated channel error per lane |
| err_count | output | 8 | Population count of `err_flags` |

## Verification
The hardest cases to reach are the two special codes, negative zero and the most negative two's complement value. Each must meet every mode and the mask in every lane position, together with hard bits that would expose a wrong sign or a missed mask.

The bench sweeps every 6-bit code through lane 0. The other lanes are filled with rotated offsets of that code, so each lane sees all 64 codes. This sweep is repeated for each mode, for every precision setting including the out-of-range ones, and with the mask both off and on. The hard bits vary per vector, so every lane meets both a matching and a mismatching decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [1:0] {
      FMT_SIGNMAG = 2'd0,
      FMT_TWOS    = 2'd1,
      FMT_REDUCED = 2'd2,
      FMT_SPARE   = 2'd3
   } fmt_mode_e;
endpackage

// File: rtl/rxf_lane_fmt.sv
module rxf_lane_fmt
   import rxf_pkg::*;
#(
   parameter int SW     = 6,
   parameter int PREC_W = 3
) (
   input  logic [1:0]        mode,
   input  logic [PREC_W-1:0] prec,
   input  logic [SW-1:0]     raw,
   output logic [SW-1:0]     fmt
);
   localparam int MW = SW - 1;
   localparam logic [MW-1:0] MAG_MAX = '1;

   logic [SW-1:0] negated;
   logic [SW-1:0] twos_res;
   logic [SW-1:0] red_res;
   fmt_mode_e     sel;

   assign sel = fmt_mode_e'(mode);

   // two's complement to sign/magnitude, most negative value saturates
   always_comb begin
      negated = -raw;
      if (raw[SW-1]) begin
         twos_res = {1'b1, (negated[SW-1] ? MAG_MAX : negated[MW-1:0])};
      end else begin
         twos_res = raw;
      end
   end

   // reduced precision: keep upper q bits, half-step bit, zero fill
   always_comb begin
      int q;
      q = int'(prec);
      red_res = raw;
      if (q >= 1 && q < SW) begin
         for (int b = 0; b < SW; b++) begin
            if (b > SW - 1 - q)       red_res[b] = raw[b];
            else if (b == SW - 1 - q) red_res[b] = 1'b1;
            else                      red_res[b] = 1'b0;
         end
      end
   end

   always_comb begin
      unique case (sel)
         FMT_TWOS:    fmt = twos_res;
         FMT_REDUCED: fmt = red_res;
         default:     fmt = raw;
      endcase
   end
endmodule

// File: rtl/rxf_err_est.sv
module rxf_err_est #(
   parameter int LANES = 8,
   parameter int SW    = 6,
   parameter int CNT_W = 8
) (
   input  logic [LANES*SW-1:0] word,
   input  logic [LANES-1:0]    hard,
   input  logic                mask_en,
   output logic [LANES-1:0]    mag,
   output logic [LANES-1:0]    err,
   output logic [CNT_W-1:0]    cnt
);
   localparam int MW = SW - 1;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [SW-1:0] lane;
      logic          raw_err;
      assign lane    = word[j*SW +: SW];
      assign mag[j]  = |lane[MW-1:0];
      assign raw_err = hard[j] ^ lane[SW-1];
      assign err[j]  = mask_en ? (raw_err & mag[j]) : raw_err;
   end

   always_comb begin
      cnt = '0;
      for (int j = 0; j < LANES; j++) begin
         cnt = cnt + CNT_W'(err[j]);
      end
   end
endmodule

// File: rtl/rx_soft_formatter.sv
module rx_soft_formatter
   import rxf_pkg::*;
#(
   parameter int LANES = 8,
   parameter int SW    = 6,
   parameter int CNT_W = 8,
   parameter int PREC_W = $clog2(SW + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [LANES*SW-1:0] in_word,
   input  logic [1:0]          fmt_mode,
   input  logic [PREC_W-1:0]   prec_bits,
   input  logic [LANES-1:0]    hard_bits,
   input  logic                mask_en,
   output logic                out_valid,
   output logic [LANES*SW-1:0] out_word,
   output logic [LANES-1:0]    mag_flags,
   output logic [LANES-1:0]    err_flags,
   output logic [CNT_W-1:0]    err_count
);
   localparam int WORD_W    = LANES * SW;
   localparam int CNT_NEED  = $clog2(LANES + 1);

   if (SW < 3) begin : g_bad_sw
      $error("rx_soft_formatter: SW must be at least 3");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("rx_soft_formatter: LANES must be at least 1");
   end
   if (CNT_W < CNT_NEED) begin : g_bad_cnt
      $error("rx_soft_formatter: CNT_W too small for LANES");
   end
   if (PREC_W < $clog2(SW + 1)) begin : g_bad_prec
      $error("rx_soft_formatter: PREC_W too small for SW");
   end

   // stage 0: per-lane format conversion
   logic [WORD_W-1:0] fmt_word;
   for (genvar j = 0; j < LANES; j++) begin : g_fmt
      rxf_lane_fmt #(.SW(SW), .PREC_W(PREC_W)) fmt_i (
         .mode (fmt_mode),
         .prec (prec_bits),
         .raw  (in_word[j*SW +: SW]),
         .fmt  (fmt_word[j*SW +: SW])
      );
   end

   // stage 1 registers
   logic              s1_valid;
   logic [WORD_W-1:0] s1_word;
   logic [LANES-1:0]  s1_hard;
   logic              s1_mask;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_word  <= '0;
         s1_hard  <= '0;
         s1_mask  <= 1'b0;
      end else begin
         s1_valid <= in_valid;
         s1_word  <= fmt_word;
         s1_hard  <= hard_bits;
         s1_mask  <= mask_en;
      end
   end

   // stage 1: magnitude flags and error estimate
   logic [LANES-1:0] est_mag;
   logic [LANES-1:0] est_err;
   logic [CNT_W-1:0] est_cnt;

   rxf_err_est #(.LANES(LANES), .SW(SW), .CNT_W(CNT_W)) est_i (
      .word    (s1_word),
      .hard    (s1_hard),
      .mask_en (s1_mask),
      .mag     (est_mag),
      .err     (est_err),
      .cnt     (est_cnt)
   );

   // stage 2 registers
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         mag_flags <= '0;
         err_flags <= '0;
         err_count <= '0;
      end else begin
         out_valid <= s1_valid;
         out_word  <= s1_word;
         mag_flags <= est_mag;
         err_flags <= est_err;
         err_count <= est_cnt;
      end
   end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int LANES = 8,
   parameter int SW    = 6,
   parameter int CNT_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [1:0]          fmt_mode,
   input logic                mask_en,
   input logic                out_valid,
   input logic [LANES*SW-1:0] out_word,
   input logic [LANES-1:0]    mag_flags,
   input logic [LANES-1:0]    err_flags,
   input logic [CNT_W-1:0]    err_count
);
   localparam int MW = SW - 1;

   logic       v_d1, v_d2, m_d1, m_d2;
   logic [1:0] md_d1, md_d2;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_d1 <= 1'b0; v_d2 <= 1'b0;
         m_d1 <= 1'b0; m_d2 <= 1'b0;
         md_d1 <= '0;  md_d2 <= '0;
      end else begin
         v_d1 <= in_valid; v_d2 <= v_d1;
         m_d1 <= mask_en;  m_d2 <= m_d1;
         md_d1 <= fmt_mode; md_d2 <= md_d1;
      end
   end

   logic [LANES-1:0] lane_nz;
   logic             neg_zero_any;
   always_comb begin
      neg_zero_any = 1'b0;
      for (int j = 0; j < LANES; j++) begin
         lane_nz[j] = |out_word[j*SW +: MW];
         if (out_word[j*SW + MW] && !lane_nz[j]) neg_zero_any = 1'b1;
      end
   end

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_d2);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && err_count == '0 && mag_flags == '0 && err_flags == '0));

   // R5
   mag_flag_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (mag_flags == lane_nz));

   // R7
   mask_erase_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && m_d2) |-> ((err_flags & ~mag_flags) == '0));

   // R8
   err_count_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (err_count == CNT_W'($countones(err_flags))));

   // R3
   twos_no_negzero_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && md_d2 == 2'd1) |-> !neg_zero_any);
endmodule

bind rx_soft_formatter rxf_checker #(.LANES(LANES), .SW(SW), .CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .fmt_mode  (fmt_mode),
   .mask_en   (mask_en),
   .out_valid (out_valid),
   .out_word  (out_word),
   .mag_flags (mag_flags),
   .err_flags (err_flags),
   .err_count (err_count)
);

// File: tb/rx_soft_formatter_tb_top.sv
module rx_soft_formatter_tb_top;
   localparam int LANES = 8;
   localparam int SW    = 6;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [47:0] in_word;
   logic [1:0]  fmt_mode;
   logic [2:0]  prec_bits;
   logic [7:0]  hard_bits;
   logic        mask_en;
   logic        out_valid;
   logic [47:0] out_word;
   logic [7:0]  mag_flags;
   logic [7:0]  err_flags;
   logic [7:0]  err_count;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   rx_soft_formatter dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .fmt_mode(fmt_mode), .prec_bits(prec_bits), .hard_bits(hard_bits),
      .mask_en(mask_en), .out_valid(out_valid), .out_word(out_word),
      .mag_flags(mag_flags), .err_flags(err_flags), .err_count(err_count)
   );

   function automatic int fmt_ref(int c, int mode, int q);
      int m;
      if (mode == 1) begin
         if (c < 32) return c;
         m = 64 - c;
         if (m > 31) m = 31;
         return 32 + m;
      end
      if (mode == 2 && q >= 1 && q <= 5) begin
         return ((c >> (6 - q)) << (6 - q)) + (1 << (5 - q));
      end
      return c;
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(int c, int mode, int q, bit msk);
      logic [47:0] ew;
      logic [7:0]  em, ee, hb;
      int          ec, f;
      string       tag;
      hb = 8'((c * 37 + mode * 11 + q * 5 + int'(msk) * 3) % 256);
      ec = 0;
      for (int j = 0; j < LANES; j++) begin
         int code;
         code = (c + 11 * j) % 64;
         in_word[j*SW +: SW] = 6'(code);
         f = fmt_ref(code, mode, q);
         ew[j*SW +: SW] = 6'(f);
         em[j] = (f % 32) != 0;
         ee[j] = hb[j] ^ (f >= 32);
         if (msk) ee[j] = ee[j] & em[j];
         if (ee[j]) ec++;
      end
      tag = (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R2";
      @(negedge clk);
      fmt_mode  = 2'(mode);
      prec_bits = 3'(q);
      hard_bits = hb;
      mask_en   = msk;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b1, "R1 valid after two edges", 64'(out_valid), 64'd1);
      check(out_word == ew, tag, 64'(out_word), 64'(ew));
      check(mag_flags == em, "R5", 64'(mag_flags), 64'(em));
      check(err_flags == ee, msk ? "R7" : "R6", 64'(err_flags), 64'(ee));
      check(err_count == 8'(ec), "R8", 64'(err_count), 64'(ec));
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid drops", 64'(out_valid), 64'd0);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b1; in_word = '1; fmt_mode = 2'd0;
      prec_bits = 3'd0; hard_bits = 8'hFF; mask_en = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(out_valid == 1'b0 && out_word == '0 && mag_flags == '0 &&
            err_flags == '0 && err_count == '0, "R1 reset",
            64'({out_valid, err_count}), 64'd0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle", 64'(out_valid), 64'd0);
      for (int msk = 0; msk < 2; msk++) begin
         for (int c = 0; c < 64; c++) begin
            run_vec(c, 0, 0, bit'(msk));
            run_vec(c, 3, 2, bit'(msk));
            run_vec(c, 1, 0, bit'(msk));
            for (int q = 0; q < 8; q++) run_vec(c, 2, q, bit'(msk));
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule